// File: doc/BRIEF.md
# Power Mode Sequencing Controller

This block decides which analog and clock blocks of a low-power data acquisition chip are powered. It keeps four power modes: Sleep, Standby, Idle and Run. A host picks a mode by writing a mode register. The serial interface decodes that write and hands it to the block as a one-cycle strobe with a register select and a data byte. Two individual power registers can also set the enable bits one at a time. The reported mode then follows from the pattern of enables that results.

Two active-low wake pins and a time-of-day alarm pulse are the wake sources. A wake in Sleep brings the chip up to Standby. A wake in any other mode turns on only the PLL, the supply monitor and the clock output, and leaves every other enable as it was.

The interrupt output goes low whenever Standby is entered. It stays low until the serial interface reports the start of the next transfer.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After `rst_ni` is released, the block is in Standby. In this state `en_o` is 7'h70, `shdn_o` is 1, `int_no` is 0 and `mode_o` is 1.
- R2: Writes to the mode registers set `en_o` to a fixed pattern and drive `shdn_o` high, one cycle after the strobe:
  - select 1 (Standby) gives 7'h70.
  - select 2 (Idle) gives 7'h7C.
  - select 3 (Run) gives 7'h7F.
  - The `en_o` bits are: 0 ADC, 1 input buffer, 2 reference, 3 DAC, 4 PLL, 5 supply monitor, 6 clock output.
- R3: A write with select 0 (Sleep) clears every bit of `en_o`, drives `shdn_o` low and reports `mode_o` = 0.
- R4: In Sleep, a falling edge on either wake pin, or an alarm pulse, moves the block to Standby. The result is `en_o` = 7'h70, `shdn_o` = 1 and `int_no` = 0.
- R5: Outside Sleep, a wake event sets `en_o` bits 6:4 and leaves bits 3:0 unchanged.
- R6: Writes to the individual power registers exit Sleep and drive `shdn_o` high.
  - Select 4 copies data bits 3:0 into `en_o` bits 3:0.
  - Select 5 copies data bits 2:0 into `en_o` bits 6:4.
  - All other enable bits are kept.
- R7: `mode_o` is decoded as follows:
  - 0 while in Sleep.
  - Otherwise 3 (Run) when all enables are on.
  - 2 (Idle) when `en_o` equals 7'h7C.
  - 1 (Standby) for any other pattern.
- R8: `xfer_start_i` releases `int_no` to 1 on the next cycle. `int_no` goes low on every entry to Standby. If Standby is entered in the same cycle as `xfer_start_i`, `int_no` stays low.
- R9: The wake pins act on falling edges only.
  - An edge changes the outputs three clock edges after the pin is first sampled low.
  - A pin held low does not trigger again.
  - A rising edge has no effect.
- R10: A mode-register write in the same cycle as a wake event takes priority, and the wake event is dropped.
- R11: A write with select 6 or 7 has no effect on `en_o`, `shdn_o` or `mode_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | One-cycle decoded register write strobe |
| reg_sel_i | input | 3 | Register select: 0 Sleep, 1 Standby, 2 Idle, 3 Run, 4 power low, 5 power high |
| reg_data_i | input | 8 | Write data for the individual power registers |
| xfer_start_i | input | 1 | Start of a serial transfer detected |
| wake_ni | input | 2 | Asynchronous active-low wake pins |
| alarm_i | input | 1 | Time-of-day alarm pulse |
| en_o | output | 7 | Per-block power enables |
| shdn_o | output | 1 | Shutdown output, low only in Sleep |
| int_no | output | 1 | Active-low interrupt |
| mode_o | output | 2 | Reported power mode |

## Verification
The assertions check the following on every cycle:
- In Sleep, all enables are off and shutdown is low.
- A wake from Sleep always lands in the Standby pattern with the interrupt low.
- A wake outside Sleep never disturbs the ADC, buffer, reference or DAC enables.
- A transfer start always releases the interrupt unless Standby is being entered.
- A synchronized edge pulse never lasts two cycles.
- Unused selects leave the state alone.

Only the bench scenarios show the rest:
- The exact pin-to-output latency.
- That a pin held low fires once.
- Write priority over a coincident alarm.
- The full path of mode transitions, including leaving Sleep through a non-Sleep register.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  localparam int NUM_BLK = 7;
  localparam int LO_BITS = 4;
  localparam int HI_BITS = NUM_BLK - LO_BITS;

  typedef enum logic [1:0] {
    MODE_SLEEP   = 2'd0,
    MODE_STANDBY = 2'd1,
    MODE_IDLE    = 2'd2,
    MODE_RUN     = 2'd3
  } pwr_mode_e;

  typedef enum logic [2:0] {
    SEL_SLEEP   = 3'd0,
    SEL_STANDBY = 3'd1,
    SEL_IDLE    = 3'd2,
    SEL_RUN     = 3'd3,
    SEL_PWR_LO  = 3'd4,
    SEL_PWR_HI  = 3'd5
  } reg_sel_e;

  // bit order: 0 adc, 1 in_buf, 2 ref, 3 dac, 4 pll, 5 mon, 6 clk_out
  localparam logic [NUM_BLK-1:0] EN_STANDBY = 7'b111_0000;
  localparam logic [NUM_BLK-1:0] EN_IDLE    = 7'b111_1100;
  localparam logic [NUM_BLK-1:0] EN_RUN     = {NUM_BLK{1'b1}};
  localparam logic [NUM_BLK-1:0] EN_WAKE    = 7'b111_0000;
endpackage

// File: rtl/pwr_wake_sync.sv
module pwr_wake_sync #(
  parameter int NUM_PINS = 2,
  parameter int STAGES   = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_ni,
  output logic [NUM_PINS-1:0] fall_o
);
  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    logic [STAGES-1:0] sh_q;
    logic              prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sh_q   <= '1;
        prev_q <= 1'b1;
      end else begin
        sh_q   <= {sh_q[STAGES-2:0], pin_ni[g]};
        prev_q <= sh_q[STAGES-1];
      end
    end

    assign fall_o[g] = prev_q & ~sh_q[STAGES-1];

    p_edge_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fall_o[g] |=> !fall_o[g]);
  end
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_wr_i,
  input  logic [2:0]         reg_sel_i,
  input  logic [DATA_W-1:0]  reg_data_i,
  input  logic               xfer_start_i,
  input  logic               wake_i,
  output logic [NUM_BLK-1:0] en_o,
  output logic               sleep_o,
  output logic               int_no
);
  logic [NUM_BLK-1:0] en_q, en_d;
  logic               sleep_q, sleep_d;
  logic               int_q, int_d;
  logic               host_hit;
  logic               std_go;
  logic               unused_data;

  assign unused_data = ^reg_data_i[DATA_W-1:LO_BITS];
  assign host_hit    = reg_wr_i && (reg_sel_i <= 3'(SEL_PWR_HI));

  always_comb begin
    en_d    = en_q;
    sleep_d = sleep_q;
    int_d   = int_q | xfer_start_i;
    std_go  = 1'b0;
    if (host_hit) begin
      unique case (reg_sel_i)
        SEL_SLEEP: begin
          en_d    = '0;
          sleep_d = 1'b1;
        end
        SEL_STANDBY: begin
          en_d    = EN_STANDBY;
          sleep_d = 1'b0;
          std_go  = 1'b1;
        end
        SEL_IDLE: begin
          en_d    = EN_IDLE;
          sleep_d = 1'b0;
        end
        SEL_RUN: begin
          en_d    = EN_RUN;
          sleep_d = 1'b0;
        end
        SEL_PWR_LO: begin
          en_d[LO_BITS-1:0] = reg_data_i[LO_BITS-1:0];
          sleep_d           = 1'b0;
        end
        default: begin
          en_d[NUM_BLK-1:LO_BITS] = reg_data_i[HI_BITS-1:0];
          sleep_d                 = 1'b0;
        end
      endcase
    end else if (wake_i) begin
      if (sleep_q) begin
        en_d    = EN_STANDBY;
        sleep_d = 1'b0;
        std_go  = 1'b1;
      end else begin
        en_d = en_q | EN_WAKE;
      end
    end
    if (std_go) int_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= EN_STANDBY;
      sleep_q <= 1'b0;
      int_q   <= 1'b0;
    end else begin
      en_q    <= en_d;
      sleep_q <= sleep_d;
      int_q   <= int_d;
    end
  end

  assign en_o    = en_q;
  assign sleep_o = sleep_q;
  assign int_no  = int_q;

  p_sleep_all_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_q |-> (en_q == '0));

  p_sleep_wake_std_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_q && wake_i && !reg_wr_i) |=> (en_q == EN_STANDBY && !sleep_q && !int_q));

  p_wake_keep_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_q && wake_i && !reg_wr_i) |=>
      (en_q[LO_BITS-1:0] == $past(en_q[LO_BITS-1:0]) && (&en_q[NUM_BLK-1:LO_BITS])));

  p_int_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_start_i && !std_go) |=> int_q);

  p_host_prio_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_sel_i == 3'(SEL_SLEEP)) |=> sleep_q);

  p_bad_sel_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_sel_i > 3'(SEL_PWR_HI) && !wake_i) |=> ($stable(en_q) && $stable(sleep_q)));
endmodule

// File: rtl/pwr_mode_decode.sv
module pwr_mode_decode
  import pwr_mode_pkg::*;
(
  input  logic [NUM_BLK-1:0] en_i,
  input  logic               sleep_i,
  output logic [1:0]         mode_o
);
  pwr_mode_e mode;

  always_comb begin
    if (sleep_i)              mode = MODE_SLEEP;
    else if (en_i == EN_RUN)  mode = MODE_RUN;
    else if (en_i == EN_IDLE) mode = MODE_IDLE;
    else                      mode = MODE_STANDBY;
  end

  assign mode_o = mode;
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int NUM_WAKE    = 2,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_wr_i,
  input  logic [2:0]          reg_sel_i,
  input  logic [DATA_W-1:0]   reg_data_i,
  input  logic                xfer_start_i,
  input  logic [NUM_WAKE-1:0] wake_ni,
  input  logic                alarm_i,
  output logic [NUM_BLK-1:0]  en_o,
  output logic                shdn_o,
  output logic                int_no,
  output logic [1:0]          mode_o
);
  logic [NUM_WAKE-1:0] fall;
  logic                wake_evt;
  logic                sleep;

  pwr_wake_sync #(.NUM_PINS(NUM_WAKE), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_ni (wake_ni),
    .fall_o (fall)
  );

  assign wake_evt = (|fall) | alarm_i;

  pwr_mode_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .reg_wr_i     (reg_wr_i),
    .reg_sel_i    (reg_sel_i),
    .reg_data_i   (reg_data_i),
    .xfer_start_i (xfer_start_i),
    .wake_i       (wake_evt),
    .en_o         (en_o),
    .sleep_o      (sleep),
    .int_no       (int_no)
  );

  pwr_mode_decode u_dec (
    .en_i    (en_o),
    .sleep_i (sleep),
    .mode_o  (mode_o)
  );

  assign shdn_o = ~sleep;

  p_sleep_shdn_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'(MODE_SLEEP)) |-> (!shdn_o && en_o == '0));

  p_all_on_run_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shdn_o && en_o == EN_RUN) |-> (mode_o == 2'(MODE_RUN)));
endmodule

// File: tb/pwr_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb_top;
  localparam int OP_WR = 0, OP_ALM = 1, OP_XF = 2, OP_W1 = 3, OP_W2 = 4;

  typedef struct packed {
    logic [2:0] op;
    logic [2:0] sel;
    logic [7:0] data;
    logic [6:0] en;
    logic [1:0] mode;
    logic       shdn;
    logic       intn;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{3'd2, 3'd0, 8'h00, 7'h70, 2'd1, 1'b1, 1'b1, 4'd8},
    '{3'd0, 3'd3, 8'h00, 7'h7F, 2'd3, 1'b1, 1'b1, 4'd2},
    '{3'd0, 3'd2, 8'h00, 7'h7C, 2'd2, 1'b1, 1'b1, 4'd2},
    '{3'd0, 3'd0, 8'h00, 7'h00, 2'd0, 1'b0, 1'b1, 4'd3},
    '{3'd3, 3'd0, 8'h00, 7'h70, 2'd1, 1'b1, 1'b0, 4'd4},
    '{3'd0, 3'd4, 8'h0F, 7'h7F, 2'd3, 1'b1, 1'b0, 4'd7},
    '{3'd2, 3'd0, 8'h00, 7'h7F, 2'd3, 1'b1, 1'b1, 4'd8},
    '{3'd0, 3'd5, 8'h00, 7'h0F, 2'd1, 1'b1, 1'b1, 4'd6},
    '{3'd1, 3'd0, 8'h00, 7'h7F, 2'd3, 1'b1, 1'b1, 4'd5},
    '{3'd0, 3'd0, 8'h00, 7'h00, 2'd0, 1'b0, 1'b1, 4'd3},
    '{3'd1, 3'd0, 8'h00, 7'h70, 2'd1, 1'b1, 1'b0, 4'd4},
    '{3'd0, 3'd0, 8'h00, 7'h00, 2'd0, 1'b0, 1'b0, 4'd3},
    '{3'd4, 3'd0, 8'h00, 7'h70, 2'd1, 1'b1, 1'b0, 4'd4},
    '{3'd0, 3'd0, 8'h00, 7'h00, 2'd0, 1'b0, 1'b0, 4'd3},
    '{3'd0, 3'd2, 8'h00, 7'h7C, 2'd2, 1'b1, 1'b0, 4'd2},
    '{3'd0, 3'd5, 8'h00, 7'h0C, 2'd1, 1'b1, 1'b0, 4'd6},
    '{3'd3, 3'd0, 8'h00, 7'h7C, 2'd2, 1'b1, 1'b0, 4'd5},
    '{3'd0, 3'd1, 8'h00, 7'h70, 2'd1, 1'b1, 1'b0, 4'd2},
    '{3'd0, 3'd0, 8'h00, 7'h00, 2'd0, 1'b0, 1'b0, 4'd3},
    '{3'd0, 3'd4, 8'h05, 7'h05, 2'd1, 1'b1, 1'b0, 4'd6}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_sel = '0;
  logic [7:0] reg_data = '0;
  logic       xfer = 1'b0;
  logic [1:0] wake_n = 2'b11;
  logic       alarm = 1'b0;
  logic [6:0] en;
  logic       shdn, int_n;
  logic [1:0] mode;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  pwr_mode_ctrl dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .reg_wr_i     (reg_wr),
    .reg_sel_i    (reg_sel),
    .reg_data_i   (reg_data),
    .xfer_start_i (xfer),
    .wake_ni      (wake_n),
    .alarm_i      (alarm),
    .en_o         (en),
    .shdn_o       (shdn),
    .int_no       (int_n),
    .mode_o       (mode)
  );

  function automatic string rname(input logic [3:0] r);
    case (r)
      4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
      4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
      4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
      4'd10: return "R10"; default: return "R11";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic [6:0] e_en, input logic [1:0] e_mode,
                         input logic e_shdn, input logic e_int);
    chk(req, "state", {en, mode, shdn, int_n}, {e_en, e_mode, e_shdn, e_int});
  endtask

  task automatic pulse(input int op, input logic [2:0] sel, input logic [7:0] data);
    @(negedge clk);
    case (op)
      OP_WR:  begin reg_wr = 1'b1; reg_sel = sel; reg_data = data; end
      OP_ALM: alarm = 1'b1;
      default: xfer = 1'b1;
    endcase
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; alarm = 1'b0; xfer = 1'b0;
  endtask

  task automatic pin_fall(input int idx);
    @(negedge clk);
    wake_n[idx] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pins_release();
    wake_n = 2'b11;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "en", en, 7'h70);
    chk("R1", "mode", mode, 2'd1);
    chk("R1", "shdn", shdn, 1'b1);
    chk("R1", "int", int_n, 1'b0);

    for (int i = 0; i < NV; i++) begin
      case (int'(VEC[i].op))
        OP_W1:   pin_fall(0);
        OP_W2:   pin_fall(1);
        default: pulse(int'(VEC[i].op), VEC[i].sel, VEC[i].data);
      endcase
      chk_all(rname(VEC[i].req), VEC[i].en, VEC[i].mode, VEC[i].shdn, VEC[i].intn);
      pins_release();
    end

    // R11 unused select leaves state (en 05, standby) alone
    pulse(OP_WR, 3'd6, 8'hFF);
    chk_all("R11", 7'h05, 2'd1, 1'b1, 1'b0);
    pulse(OP_WR, 3'd7, 8'hFF);
    chk_all("R11", 7'h05, 2'd1, 1'b1, 1'b0);

    // R10 Sleep write and alarm in the same cycle: write wins
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 3'd0; alarm = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; alarm = 1'b0;
    chk_all("R10", 7'h00, 2'd0, 1'b0, 1'b0);

    // R9 latency: still Sleep after two edges, Standby after the third
    @(negedge clk);
    wake_n[1] = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R9", "mode_early", mode, 2'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R9", "mode_late", mode, 2'd1);

    // R9 pin held low does not wake again
    pulse(OP_WR, 3'd0, 8'h00);
    repeat (6) @(negedge clk);
    chk_all("R9", 7'h00, 2'd0, 1'b0, 1'b0);
    pins_release();
    chk_all("R9", 7'h00, 2'd0, 1'b0, 1'b0);

    // R8 transfer start and Standby write together: int stays low
    pulse(OP_XF, 3'd0, 8'h00);
    chk("R8", "int_in_sleep", int_n, 1'b1);
    @(negedge clk);
    xfer = 1'b1; reg_wr = 1'b1; reg_sel = 3'd1;
    @(posedge clk);
    @(negedge clk);
    xfer = 1'b0; reg_wr = 1'b0;
    chk_all("R8", 7'h70, 2'd1, 1'b1, 1'b0);
    pulse(OP_XF, 3'd0, 8'h00);
    chk("R8", "int_release", int_n, 1'b1);

    // R5 alarm in Run changes nothing visible; R7 run decode
    pulse(OP_WR, 3'd3, 8'h00);
    pulse(OP_ALM, 3'd0, 8'h00);
    chk_all("R5", 7'h7F, 2'd3, 1'b1, 1'b1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule